// File: doc/BRIEF.md
# Four-Channel Reloading Down-Counter Timer Bank

This block is a register-mapped timer peripheral with four independent 32-bit down-counters that all run from one clock. A small memory-mapped bus carries an address, write data, a write strobe and a read strobe, and returns read data one cycle after the read strobe. A single global enable sits in a top-level control word, beside a fixed read-only revision word. Each channel adds a local enable, a reload value, a free-running underflow tally, a captured count, and an interrupt flag with its clear and mask registers.

A channel counts only while both the global enable and its own local enable are set. On reaching zero it reloads on the following cycle, adds one to its underflow tally and raises its interrupt flag. Software reads the running count as a coherent pair: reading the underflow tally also captures the count, and the count register then returns that captured value. One combined interrupt output is the OR of every channel's flag gated by its mask.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset every register reads 0 except the revision word, and `irq_o` is low.
- R2: The control word is at 0x00 with the global enable in bit 0, the revision word is at 0x10. Channel n (0..3) uses 0x20*(n+1) plus: local enable (bit 0) +0x00, reload +0x04, captured count +0x08, underflow tally +0x0C, flag (bit 0) +0x10, clear +0x14, mask (bit 0) +0x18. Read data appears in the cycle after `bus_re_i` is sampled.
- R3: Reads of any other address return 0; writes to the revision, captured count, underflow tally and flag registers, and to unmapped addresses, change nothing.
- R4: A channel's count holds its value unless both the global enable and its local enable are 1.
- R5: While enabled and non-zero, the count falls by one each cycle.
- R6: While enabled at zero, the next cycle loads the reload value and adds one to the 32-bit underflow tally, giving a period of reload+1 cycles; a reload of 0xFFFFFFFF works.
- R7: Writing 1 to a local enable that is 0 loads the reload value into the count, whatever the global enable.
- R8: Reading the underflow tally returns the tally and captures the count as it stood before that cycle; the captured-count register returns that value and does not change until the next tally read.
- R9: Each underflow sets the channel flag; writing 1 to bit 0 of the clear register resets it, but an underflow in the same cycle keeps it set.
- R10: `irq_o` is high exactly when some channel has both its flag and its mask bit set; masks reset to 0.
- R11: Channels count, tally and flag independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 8 | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
Counting is tried with a reload of zero (an underflow every cycle), a short reload of three that wraps many times, a long reload that never wraps during the run, and the all-ones reload; the first two tell a correct period of reload+1 apart from an off-by-one, the last two show plain decrement and full width. The captured count is read twice with time between to tell a captured value from a live one, and a channel enabled while the global enable is off tells the two-enable gate from a single one. The flag is cleared once with the channel stopped and once under an underflow every cycle, which separates clear from event priority.

// File: rtl/gpt_pkg.sv
// Shared register selector type and word offsets for the timer bank.
// Assumes 32-byte slots: slot 0 holds the top-level words, slot n+1 holds channel n.
package gpt_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_REV,
        SEL_CFG,
        SEL_RELOAD,
        SEL_CUR,
        SEL_OVF,
        SEL_STAT,
        SEL_CLR,
        SEL_MASK
    } reg_sel_e;

    localparam int SLOT_LSB = 5;

    // offsets inside slot 0
    localparam logic [4:0] OFS_CTRL   = 5'h00;
    localparam logic [4:0] OFS_REV    = 5'h10;
    // offsets inside a channel slot
    localparam logic [4:0] OFS_CFG    = 5'h00;
    localparam logic [4:0] OFS_RELOAD = 5'h04;
    localparam logic [4:0] OFS_CUR    = 5'h08;
    localparam logic [4:0] OFS_OVF    = 5'h0C;
    localparam logic [4:0] OFS_STAT   = 5'h10;
    localparam logic [4:0] OFS_CLR    = 5'h14;
    localparam logic [4:0] OFS_MASK   = 5'h18;

endpackage

// File: rtl/gpt_addr_decode.sv
// Address decoder: turns a byte address into a register selector and a
// channel index. Assumes AW is wide enough to reach slot NUM_CH.
// Misaligned or unmapped addresses give SEL_NONE.
module gpt_addr_decode #(
    parameter int AW     = 8,
    parameter int NUM_CH = 4,
    parameter int CHW    = 2
) (
    input  logic [AW-1:0]         addr_i,
    output gpt_pkg::reg_sel_e     sel_o,
    output logic [CHW-1:0]        ch_o
);
    import gpt_pkg::*;

    localparam int SW = AW - SLOT_LSB;

    logic [SW-1:0] slot;
    logic [4:0]    off;

    assign slot = addr_i[AW-1:SLOT_LSB];
    assign off  = addr_i[SLOT_LSB-1:0];

    // Map slot and offset to a selector
    always_comb begin
        sel_o = SEL_NONE;
        ch_o  = '0;
        if (slot == '0) begin
            case (off)
                OFS_CTRL: sel_o = SEL_CTRL;
                OFS_REV:  sel_o = SEL_REV;
                default:  sel_o = SEL_NONE;
            endcase
        end else if (int'(slot) <= NUM_CH) begin
            ch_o = CHW'(slot - SW'(1));
            case (off)
                OFS_CFG:    sel_o = SEL_CFG;
                OFS_RELOAD: sel_o = SEL_RELOAD;
                OFS_CUR:    sel_o = SEL_CUR;
                OFS_OVF:    sel_o = SEL_OVF;
                OFS_STAT:   sel_o = SEL_STAT;
                OFS_CLR:    sel_o = SEL_CLR;
                OFS_MASK:   sel_o = SEL_MASK;
                default:    sel_o = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/gpt_counter.sv
// One channel's counting path: local enable, reload register, down-counter,
// underflow tally and captured count. Assumes strobes are single-cycle and
// mutually exclusive, as a one-access-per-cycle bus provides.
module gpt_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          glb_en_i,
    input  logic          cfg_we_i,
    input  logic          cfg_en_i,
    input  logic          reload_we_i,
    input  logic [CW-1:0] reload_d_i,
    input  logic          snap_req_i,
    output logic          local_en_o,
    output logic [CW-1:0] reload_o,
    output logic [CW-1:0] snap_o,
    output logic [CW-1:0] ovf_o,
    output logic          evt_o
);
    logic          local_q;
    logic [CW-1:0] reload_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] ovf_q;
    logic [CW-1:0] snap_q;
    logic          load;
    logic          run;
    logic          evt;

    assign load = cfg_we_i && cfg_en_i && !local_q;
    assign run  = glb_en_i && local_q;
    assign evt  = run && (cnt_q == '0);

    // Local enable follows writes of the enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)        local_q <= 1'b0;
        else if (cfg_we_i) local_q <= cfg_en_i;
    end

    // Reload value register
    always_ff @(posedge clk) begin
        if (!rst_n)           reload_q <= '0;
        else if (reload_we_i) reload_q <= reload_d_i;
    end

    // Down-counter: load on enable rise, reload after zero, else decrement
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= reload_q;
        else if (evt)  cnt_q <= reload_q;
        else if (run)  cnt_q <= cnt_q - CW'(1);
    end

    // Underflow tally
    always_ff @(posedge clk) begin
        if (!rst_n)   ovf_q <= '0;
        else if (evt) ovf_q <= ovf_q + CW'(1);
    end

    // Captured count, taken when the tally is read
    always_ff @(posedge clk) begin
        if (!rst_n)          snap_q <= '0;
        else if (snap_req_i) snap_q <= cnt_q;
    end

    assign local_en_o = local_q;
    assign reload_o   = reload_q;
    assign snap_o     = snap_q;
    assign ovf_o      = ovf_q;
    assign evt_o      = evt;

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(glb_en_i && local_q) && !load) |=> $stable(cnt_q));

    a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en_i && local_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en_i && local_q && cnt_q == '0)
            |=> (cnt_q == $past(reload_q)) && (ovf_q == $past(ovf_q) + CW'(1)));

    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_en_i && !local_q) |=> (local_q && cnt_q == $past(reload_q)));

    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req_i |=> (snap_q == $past(cnt_q)));

endmodule

// File: rtl/gpt_irq_flag.sv
// One channel's interrupt flag and mask. An underflow sets the flag and wins
// over a clear in the same cycle. Produces the masked request for the OR tree.
module gpt_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_we_i,
    input  logic clr_bit_i,
    input  logic mask_we_i,
    input  logic mask_bit_i,
    output logic stat_o,
    output logic mask_o,
    output logic req_o
);
    logic stat_q;
    logic mask_q;
    logic clr;

    assign clr = clr_we_i && clr_bit_i;

    // Flag: set by an event, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n)     stat_q <= 1'b0;
        else if (evt_i) stat_q <= 1'b1;
        else if (clr)   stat_q <= 1'b0;
    end

    // Mask bit register
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= 1'b0;
        else if (mask_we_i) mask_q <= mask_bit_i;
    end

    assign stat_o = stat_q;
    assign mask_o = mask_q;
    assign req_o  = stat_q && mask_q;

    a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> stat_q);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && clr_bit_i && !evt_i) |=> !stat_q);

    a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_i && !(clr_we_i && clr_bit_i)) |=> $stable(stat_q));

endmodule

// File: rtl/gp_timer_bank.sv
// Timer bank top: global enable, revision word, NUM_CH channels, read mux
// with one cycle of read latency, and the combined interrupt.
// Assumes at most one bus access per cycle (read and write share the address).
module gp_timer_bank #(
    parameter int          NUM_CH = 4,
    parameter int          AW     = 8,
    parameter int          DW     = 32,
    parameter logic [31:0] REV    = 32'h0001_0300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr_i,
    input  logic [DW-1:0] bus_wdata_i,
    input  logic          bus_we_i,
    input  logic          bus_re_i,
    output logic [DW-1:0] bus_rdata_o,
    output logic          irq_o
);
    import gpt_pkg::*;

    localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    reg_sel_e      dec_sel;
    logic [CHW-1:0] dec_ch;
    logic          glb_q;
    logic [DW-1:0] rd_val;
    logic [DW-1:0] rdata_q;

    logic          loc_a    [NUM_CH];
    logic [DW-1:0] reload_a [NUM_CH];
    logic [DW-1:0] snap_a   [NUM_CH];
    logic [DW-1:0] ovf_a    [NUM_CH];
    logic          stat_a   [NUM_CH];
    logic          mask_a   [NUM_CH];
    logic [NUM_CH-1:0] req_vec;
    logic [NUM_CH-1:0] mask_vec;

    gpt_addr_decode #(.AW(AW), .NUM_CH(NUM_CH), .CHW(CHW)) u_dec (
        .addr_i (bus_addr_i),
        .sel_o  (dec_sel),
        .ch_o   (dec_ch)
    );

    // Global enable bit of the control word
    always_ff @(posedge clk) begin
        if (!rst_n)                             glb_q <= 1'b0;
        else if (bus_we_i && dec_sel == SEL_CTRL) glb_q <= bus_wdata_i[0];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic         hit;
        logic         evt;
        assign hit = (dec_ch == CHW'(i));

        gpt_counter #(.CW(DW)) u_cnt (
            .clk         (clk),
            .rst_n       (rst_n),
            .glb_en_i    (glb_q),
            .cfg_we_i    (bus_we_i && hit && dec_sel == SEL_CFG),
            .cfg_en_i    (bus_wdata_i[0]),
            .reload_we_i (bus_we_i && hit && dec_sel == SEL_RELOAD),
            .reload_d_i  (bus_wdata_i),
            .snap_req_i  (bus_re_i && hit && dec_sel == SEL_OVF),
            .local_en_o  (loc_a[i]),
            .reload_o    (reload_a[i]),
            .snap_o      (snap_a[i]),
            .ovf_o       (ovf_a[i]),
            .evt_o       (evt)
        );

        gpt_irq_flag u_flag (
            .clk        (clk),
            .rst_n      (rst_n),
            .evt_i      (evt),
            .clr_we_i   (bus_we_i && hit && dec_sel == SEL_CLR),
            .clr_bit_i  (bus_wdata_i[0]),
            .mask_we_i  (bus_we_i && hit && dec_sel == SEL_MASK),
            .mask_bit_i (bus_wdata_i[0]),
            .stat_o     (stat_a[i]),
            .mask_o     (mask_a[i]),
            .req_o      (req_vec[i])
        );

        assign mask_vec[i] = mask_a[i];
    end

    // Read mux over the selected register
    always_comb begin
        rd_val = '0;
        case (dec_sel)
            SEL_CTRL:   rd_val = DW'(glb_q);
            SEL_REV:    rd_val = DW'(REV);
            SEL_CFG:    rd_val = DW'(loc_a[dec_ch]);
            SEL_RELOAD: rd_val = reload_a[dec_ch];
            SEL_CUR:    rd_val = snap_a[dec_ch];
            SEL_OVF:    rd_val = ovf_a[dec_ch];
            SEL_STAT:   rd_val = DW'(stat_a[dec_ch]);
            SEL_MASK:   rd_val = DW'(mask_a[dec_ch]);
            default:    rd_val = '0;
        endcase
    end

    // Registered read data, updated on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (bus_re_i) rdata_q <= rd_val;
    end

    assign bus_rdata_o = rdata_q;
    assign irq_o       = |req_vec;

    a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re_i && dec_sel == SEL_NONE) |=> (bus_rdata_o == '0));

    a_r2_revision: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re_i && dec_sel == SEL_REV) |=> (bus_rdata_o == DW'(REV)));

    a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_vec == '0) |-> !irq_o);

    a_r1_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re_i |=> $stable(bus_rdata_o));

endmodule

// File: tb/tb_gp_timer_bank.sv
`timescale 1ns/1ps
module tb_gp_timer_bank;
    localparam logic [31:0] REV  = 32'h0001_0300;
    localparam longint      PER  = 8;
    localparam longint      HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    longint last_edge;
    logic [31:0] snap_exp [4];

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    always #4 clk = ~clk;

    gp_timer_bank #(.REV(REV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_we_i(wr_en), .bus_re_i(rd_en), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop the expected item for each completed read
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) check("scoreboard underrun", 32'h1, 32'h0);
            else check(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(posedge clk); last_edge = longint'($time);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk); addr = a; rd_en = 1'b1; wr_en = 1'b0;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    // Tally read with expected tally and captured count from the period model
    task automatic rd_ovf(input int c, input longint r, input longint t_en, input string tag);
        longint t_rd, j, eo;
        @(negedge clk);
        t_rd = longint'($time) + HALF;
        j = (t_rd - t_en) / PER - 1;
        eo = j / (r + 1);
        snap_exp[c] = 32'(r - (j % (r + 1)));
        addr = 8'(8'h2C + 8'h20 * c); rd_en = 1'b1; wr_en = 1'b0;
        exp_q.push_back(32'(eo)); tag_q.push_back(tag);
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        check(tag, {31'b0, irq}, {31'b0, e});
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        longint t0, t1, t2, t3;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(8'h10, REV,   "R1 R2 revision");
        rd(8'h00, 32'h0, "R1 control");
        rd(8'h20, 32'h0, "R1 ch0 enable");
        rd(8'h98, 32'h0, "R1 ch3 mask");
        rd(8'h64, 32'h0, "R1 ch2 reload");
        rd(8'h4C, 32'h0, "R1 ch1 tally");
        chk_irq(1'b0, "R1 irq low");

        // R3 unmapped and read-only
        rd(8'h04, 32'h0, "R3 unmapped 0x04");
        rd(8'h3C, 32'h0, "R3 unmapped 0x3C");
        rd(8'hA0, 32'h0, "R3 unmapped 0xA0");
        rd(8'hFC, 32'h0, "R3 unmapped 0xFC");
        wr(8'h10, 32'hDEAD_BEEF);
        rd(8'h10, REV, "R3 revision write ignored");
        wr(8'h28, 32'h5);
        wr(8'h2C, 32'h7);
        rd(8'h2C, 32'h0, "R3 tally write ignored");
        rd(8'h28, 32'h0, "R3 captured write ignored");

        // R4 R7: local enable with global off loads but does not count
        wr(8'h24, 32'd100);
        wr(8'h20, 32'h1);
        idle(10);
        rd(8'h2C, 32'h0,   "R4 no tally with global off");
        rd(8'h28, 32'd100, "R4 R7 loaded and held");
        rd(8'h20, 32'h1,   "R2 local enable readback");

        // R4 local off holds under global on
        wr(8'h20, 32'h0);
        wr(8'h00, 32'h1);
        rd(8'h00, 32'h1, "R2 global enable readback");
        idle(5);
        rd(8'h2C, 32'h0,   "R4 local off tally");
        rd(8'h28, 32'd100, "R4 local off holds");

        // R5 R6 R8 R11: two channels with different reloads
        wr(8'h44, 32'd3);
        wr(8'h40, 32'h1); t1 = last_edge;
        wr(8'h24, 32'd1000);
        wr(8'h20, 32'h1); t0 = last_edge;
        idle(13);
        rd_ovf(1, 3, t1, "R6 R11 ch1 tally");
        rd(8'h48, snap_exp[1], "R6 ch1 captured");
        rd_ovf(0, 1000, t0, "R5 R11 ch0 tally");
        rd(8'h28, snap_exp[0], "R5 ch0 captured");
        idle(20);
        rd(8'h48, snap_exp[1], "R8 captured unchanged");
        rd_ovf(1, 3, t1, "R6 ch1 tally again");
        rd(8'h48, snap_exp[1], "R8 ch1 captured refreshed");

        // R6 full-width reload
        wr(8'h64, 32'hFFFF_FFFF);
        wr(8'h60, 32'h1); t2 = last_edge;
        idle(5);
        rd_ovf(2, 64'h0_FFFF_FFFF, t2, "R6 R11 ch2 tally");
        rd(8'h68, snap_exp[2], "R6 ch2 all-ones count");

        // R7 re-enable loads new reload
        wr(8'h20, 32'h0);
        wr(8'h24, 32'd50);
        wr(8'h20, 32'h1); t0 = last_edge;
        idle(3);
        rd_ovf(0, 50, t0, "R7 ch0 tally");
        rd(8'h28, snap_exp[0], "R7 ch0 reloaded count");

        // R9 R10 flag, mask and clear
        rd(8'h50, 32'h1, "R9 ch1 flag set");
        chk_irq(1'b0, "R10 masked flag");
        wr(8'h58, 32'h1);
        chk_irq(1'b1, "R10 unmasked flag");
        rd(8'h58, 32'h1, "R10 mask readback");
        wr(8'h40, 32'h0);
        wr(8'h54, 32'h1);
        chk_irq(1'b0, "R9 R10 cleared");
        rd(8'h50, 32'h0, "R9 flag cleared");
        wr(8'h50, 32'h1);
        rd(8'h50, 32'h0, "R3 flag write ignored");

        // R9 event wins over clear; R6 reload zero
        wr(8'h80, 32'h1); t3 = last_edge;
        wr(8'h94, 32'h1);
        rd(8'h90, 32'h1, "R9 event beats clear");
        chk_irq(1'b0, "R10 ch3 masked");
        rd_ovf(3, 0, t3, "R6 reload zero tally");
        rd(8'h88, snap_exp[3], "R6 reload zero count");
        wr(8'h98, 32'h1);
        chk_irq(1'b1, "R10 ch3 unmasked");

        idle(4);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(PER * 200000);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule